// File: doc/BRIEF.md
# Single-Bit Byte Shifter with Link Fill

This block shifts one register operand by one bit position per command, either towards the most significant end or towards the least significant end. The bit position left empty by the shift is filled with zero, with the current link bit, or with a forced one. The bit that falls off the far end always becomes the new link bit. Because the link bit can be both the fill source and the catch for the lost bit, a sequence of commands can rotate a value through link or carry a shift across several bytes.

Each command also carries a flag-update request, a file-write inhibit and a destination code. The shifted value is presented on a registered result port with a file-write strobe, unless the write is inhibited, and with a destination-write strobe, unless the destination code is zero. With the flag request set, the zero and negative flags describe the result and the overflow flag copies the bit that was shifted out. The link bit, the three flags and the result are all registered, so every command takes effect on the clock edge that samples it.

Top module: `bitshift_link_unit`

## Requirements
- R1: After reset, every output is zero: result, both write strobes, destination code, link bit and the zero, negative and overflow flags.
- R2: When `cmd_ctl[1]` is 1 the shift goes towards bit 0: the result is the fill bit followed by `src_val[DATA_W-1:1]`, and the new link bit is `src_val[0]`.
- R3: When `cmd_ctl[1]` is 0 the shift goes towards the top: the result is `src_val[DATA_W-2:0]` followed by the fill bit, and the new link bit is `src_val[DATA_W-1]`.
- R4: The fill bit is `(cmd_ctl[3] & link) | cmd_ctl[2]`, using the link value held before the command: zero when both bits are clear, the old link when only `cmd_ctl[3]` is set, one whenever `cmd_ctl[2]` is set.
- R5: Every accepted command replaces the link bit with the shifted-out bit, whatever the flag request, inhibit or destination code.
- R6: With `cmd_ctl[0]` set, the zero flag is 1 exactly when the result is all zeros, the negative flag is the result's top bit, and the overflow flag is the shifted-out bit.
- R7: With `cmd_ctl[0]` clear, the zero, negative and overflow flags keep their values.
- R8: `file_wr_q` is 1 in the cycle after an accepted command whose `file_inhibit` is 0, and 0 otherwise.
- R9: `dest_wr_q` is 1 in the cycle after an accepted command whose `dest_code` is nonzero; `dest_code_q` then carries that code. A zero code writes no destination.
- R10: In a cycle without `cmd_valid`, both strobes drop to 0 and the result, link and flags keep their values.
- R11: All results of a command appear one clock after the edge that samples it, so back-to-back commands chain through link with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A shift command is present this cycle |
| cmd_ctl | input | 4 | [3] fill with link, [2] fill with one, [1] shift towards bit 0, [0] update flags |
| src_val | input | DATA_W | Operand read from the file register |
| file_inhibit | input | 1 | Suppress the write back to the file register |
| dest_code | input | DEST_W | Destination register code; zero means none |
| result_q | output | DATA_W | Shifted value |
| file_wr_q | output | 1 | File-register write strobe |
| dest_wr_q | output | 1 | Destination-register write strobe |
| dest_code_q | output | DEST_W | Registered destination code |
| link_q | output | 1 | Link bit |
| flag_z_q | output | 1 | Zero flag |
| flag_n_q | output | 1 | Negative flag |
| flag_v_q | output | 1 | Overflow flag |

## Verification
The bench targets the fill with link, where a design that reads the link after its own update would fill with the new bit and break rotates; a right shift of 0x38 with link 1 that returned 0x1C instead of 0x9C would show it. Both fill bits together must give one, not zero or link alone. The flag request is toggled off after a command that set all three flags, so a design that updated or cleared flags on every shift would be seen, and shifts with destination code zero and inhibit set must still move the link while raising no strobe.

// File: rtl/bitshift_link_pkg.sv
package bitshift_link_pkg;

   typedef struct packed {
      logic fill_link;
      logic fill_one;
      logic dir_right;
      logic flag_upd;
   } shift_ctl_t;

   typedef enum logic [0:0] {
      ZDET_REDUCE = 1'b0,
      ZDET_CHAIN  = 1'b1
   } zdet_style_e;

endpackage

// File: rtl/bsl_fill_sel.sv
module bsl_fill_sel
   import bitshift_link_pkg::*;
(
   input  shift_ctl_t ctl,
   input  logic       link_cur,
   output logic       fill_bit
);
   always_comb begin
      fill_bit = (ctl.fill_link & link_cur) | ctl.fill_one;
   end
endmodule

// File: rtl/bsl_shift_core.sv
module bsl_shift_core #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] src,
   input  logic              dir_right,
   input  logic              fill_bit,
   output logic [DATA_W-1:0] shifted,
   output logic              spill_bit
);
   localparam int TOP = DATA_W - 1;

   logic [DATA_W-1:0] toward_lo;
   logic [DATA_W-1:0] toward_hi;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == TOP) begin : g_top
         assign toward_lo[i] = fill_bit;
      end else begin : g_mid_lo
         assign toward_lo[i] = src[i+1];
      end
      if (i == 0) begin : g_bot
         assign toward_hi[i] = fill_bit;
      end else begin : g_mid_hi
         assign toward_hi[i] = src[i-1];
      end
   end

   always_comb begin
      shifted   = dir_right ? toward_lo : toward_hi;
      spill_bit = dir_right ? src[0] : src[TOP];
   end
endmodule

// File: rtl/bsl_flag_eval.sv
module bsl_flag_eval
   import bitshift_link_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter zdet_style_e ZSTYLE = ZDET_CHAIN
) (
   input  logic [DATA_W-1:0] value,
   input  logic              spill_bit,
   output logic              is_zero,
   output logic              is_neg,
   output logic              is_ovf
);
   logic any_set;

   if (ZSTYLE == ZDET_CHAIN) begin : g_chain
      logic [DATA_W-1:0] acc;
      assign acc[0] = value[0];
      for (genvar i = 1; i < DATA_W; i++) begin : g_link
         assign acc[i] = acc[i-1] | value[i];
      end
      assign any_set = acc[DATA_W-1];
   end else begin : g_reduce
      assign any_set = |value;
   end

   always_comb begin
      is_zero = ~any_set;
      is_neg  = value[DATA_W-1];
      is_ovf  = spill_bit;
   end
endmodule

// File: rtl/bitshift_link_unit.sv
module bitshift_link_unit
   import bitshift_link_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter int          DEST_W = 4,
   parameter zdet_style_e ZSTYLE = ZDET_CHAIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_ctl,
   input  logic [DATA_W-1:0] src_val,
   input  logic              file_inhibit,
   input  logic [DEST_W-1:0] dest_code,
   output logic [DATA_W-1:0] result_q,
   output logic              file_wr_q,
   output logic              dest_wr_q,
   output logic [DEST_W-1:0] dest_code_q,
   output logic              link_q,
   output logic              flag_z_q,
   output logic              flag_n_q,
   output logic              flag_v_q
);
   localparam logic [DEST_W-1:0] NO_DEST = '0;

   if (DATA_W < 2) begin : g_bad_width
      $error("bitshift_link_unit: DATA_W must be at least 2");
   end
   if (DEST_W < 1) begin : g_bad_dest
      $error("bitshift_link_unit: DEST_W must be at least 1");
   end

   shift_ctl_t        ctl;
   logic              fill_bit;
   logic [DATA_W-1:0] shifted;
   logic              spill_bit;
   logic              nz_zero;
   logic              nz_neg;
   logic              nz_ovf;

   assign ctl = shift_ctl_t'(cmd_ctl);

   bsl_fill_sel u_fill (
      .ctl      (ctl),
      .link_cur (link_q),
      .fill_bit (fill_bit)
   );

   bsl_shift_core #(.DATA_W(DATA_W)) u_core (
      .src       (src_val),
      .dir_right (ctl.dir_right),
      .fill_bit  (fill_bit),
      .shifted   (shifted),
      .spill_bit (spill_bit)
   );

   bsl_flag_eval #(.DATA_W(DATA_W), .ZSTYLE(ZSTYLE)) u_flags (
      .value     (shifted),
      .spill_bit (spill_bit),
      .is_zero   (nz_zero),
      .is_neg    (nz_neg),
      .is_ovf    (nz_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q    <= '0;
         file_wr_q   <= 1'b0;
         dest_wr_q   <= 1'b0;
         dest_code_q <= '0;
         link_q      <= 1'b0;
      end else begin
         file_wr_q <= cmd_valid & ~file_inhibit;
         dest_wr_q <= cmd_valid & (dest_code != NO_DEST);
         if (cmd_valid) begin
            result_q    <= shifted;
            dest_code_q <= dest_code;
            link_q      <= spill_bit;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_z_q <= 1'b0;
         flag_n_q <= 1'b0;
         flag_v_q <= 1'b0;
      end else if (cmd_valid && ctl.flag_upd) begin
         flag_z_q <= nz_zero;
         flag_n_q <= nz_neg;
         flag_v_q <= nz_ovf;
      end
   end
endmodule

// File: rtl/bitshift_link_chk.sv
module bitshift_link_chk #(
   parameter int DATA_W = 8,
   parameter int DEST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_ctl,
   input  logic [DATA_W-1:0] src_val,
   input  logic              file_inhibit,
   input  logic [DEST_W-1:0] dest_code,
   input  logic [DATA_W-1:0] result_q,
   input  logic              file_wr_q,
   input  logic              dest_wr_q,
   input  logic [DEST_W-1:0] dest_code_q,
   input  logic              link_q,
   input  logic              flag_z_q,
   input  logic              flag_n_q,
   input  logic              flag_v_q
);
   // R2
   right_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ctl[1]) |=> (link_q == $past(src_val[0])));

   // R3
   left_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ctl[1]) |=> (link_q == $past(src_val[DATA_W-1])));

   // R6
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ctl[0]) |=> (flag_z_q == (result_q == '0)) &&
                                    (flag_n_q == result_q[DATA_W-1]) &&
                                    (flag_v_q == link_q));

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ctl[0]) |=> $stable(flag_z_q) && $stable(flag_n_q) && $stable(flag_v_q));

   // R8
   file_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !file_inhibit) |=> file_wr_q);

   // R9
   dest_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dest_wr_q |-> (dest_code_q != '0));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !file_wr_q && !dest_wr_q && $stable(link_q) && $stable(result_q));
endmodule

bind bitshift_link_unit bitshift_link_chk #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_ctl      (cmd_ctl),
   .src_val      (src_val),
   .file_inhibit (file_inhibit),
   .dest_code    (dest_code),
   .result_q     (result_q),
   .file_wr_q    (file_wr_q),
   .dest_wr_q    (dest_wr_q),
   .dest_code_q  (dest_code_q),
   .link_q       (link_q),
   .flag_z_q     (flag_z_q),
   .flag_n_q     (flag_n_q),
   .flag_v_q     (flag_v_q)
);

// File: tb/tb_bitshift_link_unit.sv
`timescale 1ns/1ps
module tb_bitshift_link_unit;
   localparam int DW = 8;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [3:0]    cmd_ctl = '0;
   logic [DW-1:0] src_val = '0;
   logic          file_inhibit = 1'b0;
   logic [CW-1:0] dest_code = '0;
   logic [DW-1:0] result_q;
   logic          file_wr_q, dest_wr_q, link_q, flag_z_q, flag_n_q, flag_v_q;
   logic [CW-1:0] dest_code_q;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // reference state
   logic [DW-1:0] m_res = '0;
   logic          m_fw = 0, m_dw = 0, m_link = 0, m_z = 0, m_n = 0, m_v = 0;
   logic [CW-1:0] m_dc = '0;

   always #2.5 clk = ~clk;

   bitshift_link_unit #(.DATA_W(DW), .DEST_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ctl(cmd_ctl),
      .src_val(src_val), .file_inhibit(file_inhibit), .dest_code(dest_code),
      .result_q(result_q), .file_wr_q(file_wr_q), .dest_wr_q(dest_wr_q),
      .dest_code_q(dest_code_q), .link_q(link_q), .flag_z_q(flag_z_q),
      .flag_n_q(flag_n_q), .flag_v_q(flag_v_q));

   task automatic compare(input string tag);
      total++;
      if (result_q !== m_res || file_wr_q !== m_fw || dest_wr_q !== m_dw ||
          dest_code_q !== m_dc || link_q !== m_link || flag_z_q !== m_z ||
          flag_n_q !== m_n || flag_v_q !== m_v) begin
         bad++;
         $display("FAIL %s: got res=%h fw=%b dw=%b dc=%h l=%b z=%b n=%b v=%b expected res=%h fw=%b dw=%b dc=%h l=%b z=%b n=%b v=%b",
                  tag, result_q, file_wr_q, dest_wr_q, dest_code_q, link_q, flag_z_q, flag_n_q, flag_v_q,
                  m_res, m_fw, m_dw, m_dc, m_link, m_z, m_n, m_v);
      end
   endtask

   // one clock: drive at falling edge, model updates at the rising edge, compare at the next falling edge
   task automatic step(input bit v, input logic [3:0] c, input logic [DW-1:0] s,
                       input bit inh, input logic [CW-1:0] d, input string tag);
      int fill;
      int out;
      int r;
      cmd_valid = v; cmd_ctl = c; src_val = s; file_inhibit = inh; dest_code = d;
      @(posedge clk);
      m_fw = v && !inh;
      m_dw = v && (d != 0);
      if (v) begin
         fill = ((c[3] && m_link) || c[2]) ? 1 : 0;
         if (c[1]) begin
            out = s[0];
            r = (int'(s) >> 1) + fill * 128;
         end else begin
            out = s[DW-1];
            r = ((int'(s) * 2) % 256) + fill;
         end
         m_res = r[DW-1:0];
         m_link = (out != 0);
         m_dc = d;
         if (c[0]) begin
            m_z = (r == 0);
            m_n = (r >= 128);
            m_v = (out != 0);
         end
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");
      // ctl bits: [3] fill link, [2] fill one, [1] right, [0] flags
      step(1, 4'b0010, 8'h69, 0, 4'h1, "R2 right 69->34");
      step(1, 4'b0000, 8'h69, 0, 4'h1, "R3 left 69->D2");
      step(1, 4'b0000, 8'h80, 1, 4'h0, "R5 link set with no destination");
      step(1, 4'b1010, 8'h38, 0, 4'h2, "R4 right fill link 38->9C");
      step(1, 4'b0100, 8'h8A, 0, 4'h3, "R4 left fill one 8A->15");
      step(1, 4'b1100, 8'h00, 0, 4'h3, "R4 both fill bits give one");
      step(1, 4'b1000, 8'h00, 0, 4'h3, "R4 fill link zero");
      step(1, 4'b0001, 8'hCB, 0, 4'h1, "R6 left flags CB->96");
      step(1, 4'b0011, 8'h01, 0, 4'h1, "R6 right flags 01->00");
      step(1, 4'b0010, 8'hF0, 0, 4'h1, "R7 flags held");
      step(1, 4'b0000, 8'h55, 1, 4'h4, "R8 inhibit");
      step(1, 4'b0000, 8'h55, 0, 4'h0, "R9 zero destination");
      step(1, 4'b0000, 8'hFF, 1, 4'h0, "R5 link with no writes");
      step(0, 4'b1111, 8'h12, 0, 4'h7, "R10 idle");
      step(0, 4'b0000, 8'h00, 1, 4'h0, "R10 idle again");
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 5) != 0, 4'($urandom), 8'($urandom), 1'($urandom),
              4'($urandom), "R11 back-to-back random");
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule